// File: doc/BRIEF.md
# Serial-Clocked EEPROM Target Model

This block models the target side of a small three-wire serial EEPROM. A host selects it with a chip-select line, shifts a start bit, a two-bit opcode and a six-bit address field in on a data-in line, one bit per rising edge of a serial clock, and receives read data on a data-out line. The array holds sixteen 16-bit words in flip-flops. A protect-select pin redirects the read, write and lock opcodes from the array to an 8-bit boundary register. Every array address at or above that boundary refuses writes.

A read streams one logic-0 dummy bit and then the addressed word, most significant bit first. If the host keeps clocking, the following words stream out back to back with no dummy bit, and the address wraps from 15 to 0. A write-enable latch must be set before any write to the array or the boundary register takes effect. A lock opcode freezes the boundary register for as long as the block stays out of reset.

All four pins are resynchronised into a fast system clock. Serial clock edges are detected in that domain, so the serial clock must stay well below the system clock rate.

Top module: `mw_eeprom_model`

## Requirements
- R1: After reset, data-out is 0, every array word reads as 0x0000, the boundary register reads as 0xFF and the write-enable latch is clear.
- R2: With the protect-select pin low, the frame 1,1,0 followed by two don't-care bits and the address A3..A0 (MSB first) starts a read. Data-out shows a 0 dummy bit after the rising edge that samples A0. The word bits D15..D0 follow, one per later rising edge. Data-out changes only after a serial clock rising edge or a deselect.
- R3: If clocking continues past D0, the word at the next address follows at once with no dummy bit. Address 15 is followed by address 0.
- R4: With the protect-select pin low, the frame 1,0,1, two don't-care bits and A3..A0, followed by 16 data bits MSB first, writes one word. The write commits on the 16th data bit, once per frame.
- R5: Opcode 00 with the top two field bits 11 sets the write-enable latch. Opcode 00 with those bits 00 clears it. While the latch is clear, array writes, boundary writes and lock commands have no effect.
- R6: An array write whose 4-bit address, zero-extended, is greater than or equal to the boundary register leaves that word unchanged. Writes below the boundary succeed.
- R7: With the protect-select pin high, opcode 10 outputs a 0 dummy bit and then the 8 boundary bits, MSB first.
- R8: With the protect-select pin high, opcode 01 loads the boundary register with the 6-bit field zero-extended to 8 bits.
- R9: With the protect-select pin high, opcode 11 sets a lock flag. While the flag is set, the boundary register never changes.
- R10: Deasserting chip-select abandons any frame in progress, so a partial write commits nothing. Data-out is 0 while the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in, sampled on serial clock rising edges |
| pre_i | input | 1 | Protect-select: high routes read, write and lock opcodes to the boundary register |
| do_o | output | 1 | Serial data out |

## Verification
Directed frames cover the main cases. Reads of freshly written words check the bit order and the dummy bit. A two-word read starting at address 15 separates correct wrap-around and dummy suppression from a stream that re-inserts the dummy bit or runs past the top of the array. Writes at the boundary address and one below it separate a strict comparison from an inclusive one. Writes with the latch cleared, and boundary writes after the lock, show whether those gates hold. A random mix of enable, disable, write and multi-word read frames from a fixed seed is then scored against a bench model of the array, the latch and the boundary.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_RD,
    ST_PRD,
    ST_WR,
    ST_DONE
  } mw_state_e;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic         rst_sync_n,
  output logic [W-1:0] pins_o
);

  logic [STAGES-1:0] rst_chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = rst_chain[STAGES-1];

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) chain <= '0;
      else             chain <= {chain[STAGES-2:0], pins_i[g]};
    end
    assign pins_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/mw_reg_array.sv
module mw_reg_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words[g] <= '0;
      else if (hit) words[g] <= wdata;
    end
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/mw_guard.sv
module mw_guard #(
  parameter int ADDR_W   = 4,
  parameter int PROT_W   = 8,
  parameter logic [PROT_W-1:0] PROT_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_set,
  input  logic              wen_clr,
  input  logic              pr_wr,
  input  logic [PROT_W-1:0] pr_wdata,
  input  logic              pr_lock,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] waddr,
  output logic              wen_q,
  output logic              locked_q,
  output logic [PROT_W-1:0] prot_q,
  output logic              mem_we
);

  logic              wen_d;
  logic              locked_d;
  logic [PROT_W-1:0] prot_d;
  logic              below;

  assign below  = PROT_W'(waddr) < prot_q;
  assign mem_we = wr_req && wen_q && below;

  always_comb begin
    wen_d    = wen_q;
    locked_d = locked_q;
    prot_d   = prot_q;
    if (wen_set)      wen_d = 1'b1;
    else if (wen_clr) wen_d = 1'b0;
    if (pr_wr && wen_q && !locked_q) prot_d   = pr_wdata;
    if (pr_lock && wen_q)            locked_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q    <= 1'b0;
      locked_q <= 1'b0;
      prot_q   <= PROT_RST;
    end else begin
      wen_q    <= wen_d;
      locked_q <= locked_d;
      prot_q   <= prot_d;
    end
  end

endmodule

// File: rtl/mw_serial_ctrl.sv
module mw_serial_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int PROT_W  = 8,
  parameter int FIELD_W = 6,
  parameter logic [1:0] OP_READ  = 2'b10,
  parameter logic [1:0] OP_WRITE = 2'b01,
  parameter logic [1:0] OP_EXT   = 2'b00,
  parameter logic [1:0] OP_LOCK  = 2'b11,
  parameter logic [1:0] EXT_EN   = 2'b11,
  parameter logic [1:0] EXT_DIS  = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  input  logic              pre,
  input  logic [DATA_W-1:0] rdata,
  input  logic [PROT_W-1:0] prot,
  output logic [ADDR_W-1:0] raddr,
  output logic              wr_req,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              pr_wr,
  output logic [PROT_W-1:0] pr_wdata,
  output logic              pr_lock,
  output logic              sk_rise,
  output logic              do_o
);

  localparam int HDR_W = 2 + FIELD_W;
  localparam int CNT_W = $clog2(DATA_W);

  mw_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HDR_W-1:0]  hdr_q, hdr_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              do_q, do_d;
  logic              sk_q;

  logic [HDR_W-1:0]   hdr_full;
  logic [1:0]         op;
  logic [FIELD_W-1:0] fld;

  assign sk_rise  = sk && !sk_q;
  assign hdr_full = {hdr_q[HDR_W-2:0], di};
  assign op       = hdr_full[HDR_W-1 -: 2];
  assign fld      = hdr_full[FIELD_W-1:0];
  assign raddr    = (state_q == ST_HDR) ? fld[ADDR_W-1:0] : addr_q + 1'b1;
  assign waddr    = addr_q;
  assign wdata    = {sh_q[DATA_W-2:0], di};
  assign pr_wdata = PROT_W'(fld);
  assign do_o     = do_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hdr_d   = hdr_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    do_d    = do_q;
    wr_req  = 1'b0;
    wen_set = 1'b0;
    wen_clr = 1'b0;
    pr_wr   = 1'b0;
    pr_lock = 1'b0;
    if (!cs) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      do_d    = 1'b0;
    end else if (sk_rise) begin
      case (state_q)
        ST_IDLE: begin
          if (di) begin
            state_d = ST_HDR;
            cnt_d   = '0;
          end
        end
        ST_HDR: begin
          hdr_d = hdr_full;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            cnt_d   = '0;
            addr_d  = fld[ADDR_W-1:0];
            state_d = ST_DONE;
            if (op == OP_EXT) begin
              if (fld[FIELD_W-1 -: 2] == EXT_EN)       wen_set = 1'b1;
              else if (fld[FIELD_W-1 -: 2] == EXT_DIS) wen_clr = 1'b1;
            end else if (pre) begin
              if (op == OP_READ) begin
                state_d = ST_PRD;
                sh_d    = {prot, (DATA_W-PROT_W)'(0)};
                do_d    = 1'b0;
              end else if (op == OP_WRITE) begin
                pr_wr = 1'b1;
              end else if (op == OP_LOCK) begin
                pr_lock = 1'b1;
              end
            end else begin
              if (op == OP_READ) begin
                state_d = ST_RD;
                sh_d    = rdata;
                do_d    = 1'b0;
              end else if (op == OP_WRITE) begin
                state_d = ST_WR;
              end
            end
          end
        end
        ST_RD: begin
          do_d = sh_q[DATA_W-1];
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            cnt_d  = '0;
            addr_d = addr_q + 1'b1;
            sh_d   = rdata;
          end else begin
            cnt_d = cnt_q + 1'b1;
            sh_d  = sh_q << 1;
          end
        end
        ST_PRD: begin
          do_d  = sh_q[DATA_W-1];
          sh_d  = sh_q << 1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(PROT_W - 1)) state_d = ST_DONE;
        end
        ST_WR: begin
          sh_d  = wdata;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            wr_req  = 1'b1;
            state_d = ST_DONE;
          end
        end
        default: do_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      do_q    <= 1'b0;
      sk_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      do_q    <= do_d;
      sk_q    <= sk;
    end
  end

endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int PROT_W  = 8,
  parameter int FIELD_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [PROT_W-1:0] PROT_RST = '1,
  parameter logic [1:0] OP_READ  = 2'b10,
  parameter logic [1:0] OP_WRITE = 2'b01,
  parameter logic [1:0] OP_EXT   = 2'b00,
  parameter logic [1:0] OP_LOCK  = 2'b11,
  parameter logic [1:0] EXT_EN   = 2'b11,
  parameter logic [1:0] EXT_DIS  = 2'b00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic pre_i,
  output logic do_o
);

  logic              rst_sync_n;
  logic [3:0]        pins_s;
  logic              cs_q, sk_s, di_s, pre_s;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] rdata, wdata;
  logic              wr_req, wen_set, wen_clr, pr_wr, pr_lock, sk_rise;
  logic [PROT_W-1:0] pr_wdata, prot_q;
  logic              wen_q, locked_q, mem_we;

  mw_pin_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_i     ({pre_i, di_i, sk_i, cs_i}),
    .rst_sync_n (rst_sync_n),
    .pins_o     (pins_s)
  );

  assign {pre_s, di_s, sk_s, cs_q} = pins_s;

  mw_serial_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_W(PROT_W), .FIELD_W(FIELD_W),
    .OP_READ(OP_READ), .OP_WRITE(OP_WRITE), .OP_EXT(OP_EXT), .OP_LOCK(OP_LOCK),
    .EXT_EN(EXT_EN), .EXT_DIS(EXT_DIS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs       (cs_q),
    .sk       (sk_s),
    .di       (di_s),
    .pre      (pre_s),
    .rdata    (rdata),
    .prot     (prot_q),
    .raddr    (raddr),
    .wr_req   (wr_req),
    .waddr    (waddr),
    .wdata    (wdata),
    .wen_set  (wen_set),
    .wen_clr  (wen_clr),
    .pr_wr    (pr_wr),
    .pr_wdata (pr_wdata),
    .pr_lock  (pr_lock),
    .sk_rise  (sk_rise),
    .do_o     (do_o)
  );

  mw_guard #(.ADDR_W(ADDR_W), .PROT_W(PROT_W), .PROT_RST(PROT_RST)) u_guard (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wen_set  (wen_set),
    .wen_clr  (wen_clr),
    .pr_wr    (pr_wr),
    .pr_wdata (pr_wdata),
    .pr_lock  (pr_lock),
    .wr_req   (wr_req),
    .waddr    (waddr),
    .wen_q    (wen_q),
    .locked_q (locked_q),
    .prot_q   (prot_q),
    .mem_we   (mem_we)
  );

  mw_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (mem_we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker #(
  parameter int ADDR_W = 4,
  parameter int PROT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_q,
  input logic              sk_rise,
  input logic              do_o,
  input logic              wr_req,
  input logic              mem_we,
  input logic              wen_q,
  input logic              locked_q,
  input logic [PROT_W-1:0] prot_q,
  input logic [ADDR_W-1:0] waddr
);

  assert_do_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |=> !do_o);

  assert_do_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && !sk_rise) |=> $stable(do_o));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

  assert_prot_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(prot_q));

  assert_we_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_req && wen_q));

  assert_we_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (PROT_W'(waddr) < prot_q));

  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

endmodule

bind mw_eeprom_model mw_eeprom_checker #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cs_q     (cs_q),
  .sk_rise  (sk_rise),
  .do_o     (do_o),
  .wr_req   (wr_req),
  .mem_we   (mem_we),
  .wen_q    (wen_q),
  .locked_q (locked_q),
  .prot_q   (prot_q),
  .waddr    (waddr)
);

// File: tb/mw_eeprom_model_bench.sv
`timescale 1ns/1ps
module mw_eeprom_model_bench;

  logic clk, rst_n, cs, sk, di, pre;
  logic dout;
  int   checks, errors;

  logic [15:0] m_mem [16];
  logic        m_wen, m_lock;
  logic [7:0]  m_prot;

  mw_eeprom_model u_mw_eeprom_model (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .pre_i(pre), .do_o(dout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic write_ok(input logic [3:0] a);
    return m_wen && ({4'b0, a} < m_prot);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b, output logic o);
    di = b;
    repeat (6) @(negedge clk);
    sk = 1'b1;
    repeat (6) @(negedge clk);
    o = dout;
    sk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sel(input logic p);
    pre = p;
    cs  = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    cs = 1'b0;
    di = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [5:0] fld, output logic o);
    logic [8:0] bits;
    bits = {1'b1, op, fld};
    for (int i = 8; i >= 0; i--) sk_bit(bits[i], o);
  endtask

  task automatic ext_cmd(input logic en);
    logic o;
    sel(1'b0);
    hdr(2'b00, en ? 6'b110000 : 6'b000000, o);
    desel();
    m_wen = en;
  endtask

  task automatic wr_word(input logic [3:0] a, input logic [15:0] d);
    logic o;
    sel(1'b0);
    hdr(2'b01, {2'($urandom), a}, o);
    for (int i = 15; i >= 0; i--) sk_bit(d[i], o);
    desel();
    if (write_ok(a)) m_mem[a] = d;
  endtask

  task automatic rd_words(input logic [3:0] a, input int n, input string tag);
    logic o;
    logic [15:0] w;
    sel(1'b0);
    hdr(2'b10, {2'($urandom), a}, o);
    chk("R2 dummy", {15'b0, o}, 16'h0);
    for (int k = 0; k < n; k++) begin
      for (int i = 15; i >= 0; i--) begin
        sk_bit(1'b0, o);
        w[i] = o;
      end
      chk(k == 0 ? tag : "R3 stream", w, m_mem[4'(a + k)]);
    end
    desel();
    chk("R10 idle do", {15'b0, dout}, 16'h0);
  endtask

  task automatic pr_read(input string tag);
    logic o;
    logic [7:0] v;
    sel(1'b1);
    hdr(2'b10, 6'($urandom), o);
    chk("R7 dummy", {15'b0, o}, 16'h0);
    for (int i = 7; i >= 0; i--) begin
      sk_bit(1'b0, o);
      v[i] = o;
    end
    desel();
    chk(tag, {8'h0, v}, {8'h0, m_prot});
  endtask

  task automatic pr_write(input logic [5:0] f);
    logic o;
    sel(1'b1);
    hdr(2'b01, f, o);
    desel();
    if (m_wen && !m_lock) m_prot = {2'b00, f};
  endtask

  task automatic pr_lock();
    logic o;
    sel(1'b1);
    hdr(2'b11, 6'h0, o);
    desel();
    if (m_wen) m_lock = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic o;
    checks = 0;
    errors = 0;
    void'($urandom(32'd20250611));
    for (int i = 0; i < 16; i++) m_mem[i] = 16'h0;
    m_wen = 1'b0; m_lock = 1'b0; m_prot = 8'hFF;
    cs = 0; sk = 0; di = 0; pre = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    chk("R1 do after reset", {15'b0, dout}, 16'h0);
    rd_words(4'd5, 1, "R1 array cleared");
    pr_read("R1 boundary reset");

    wr_word(4'd3, 16'hA5C3);
    rd_words(4'd3, 1, "R5 write while disabled");

    ext_cmd(1'b1);
    wr_word(4'd3, 16'hA5C3);
    rd_words(4'd3, 1, "R4 write then read");
    wr_word(4'd15, 16'h1234);
    wr_word(4'd0, 16'hBEEF);
    rd_words(4'd15, 2, "R3 wrap start");
    rd_words(4'd2, 3, "R2 multi-word");

    ext_cmd(1'b0);
    wr_word(4'd3, 16'h0F0F);
    rd_words(4'd3, 1, "R5 disabled again");

    ext_cmd(1'b1);
    pr_write(6'd8);
    pr_read("R8 boundary load");
    wr_word(4'd8, 16'h8888);
    rd_words(4'd8, 1, "R6 at boundary");
    wr_word(4'd9, 16'h9999);
    rd_words(4'd9, 1, "R6 above boundary");
    wr_word(4'd7, 16'h7777);
    rd_words(4'd7, 1, "R6 below boundary");

    sel(1'b0);
    hdr(2'b01, 6'd2, o);
    for (int i = 0; i < 10; i++) sk_bit(1'b1, o);
    cs = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 do after abort", {15'b0, dout}, 16'h0);
    desel();
    rd_words(4'd2, 1, "R10 aborted write");

    pr_lock();
    pr_write(6'd2);
    pr_read("R9 locked boundary");
    wr_word(4'd9, 16'h5A5A);
    rd_words(4'd9, 1, "R9 R6 still protected");

    for (int it = 0; it < 40; it++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0)      ext_cmd(1'b1);
      else if (r == 1) ext_cmd(1'b0);
      else if (r < 5)  wr_word(4'($urandom), 16'($urandom));
      else             rd_words(4'($urandom), 1 + int'($urandom % 3), "R4 R5 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule